// File: doc/BRIEF.md
# Ethernet Buffer-Descriptor Ring Engine

This block holds two descriptor tables, one for transmit and one for receive, inside a host-visible register window. Every descriptor is eight bytes wide and holds four 16-bit words: a control word, a spare word, a byte count and a buffer pointer. The host reads and writes these words through a simple single-cycle register port.

On the transmit side a host write that sets the ready flag in a transmit control word starts a send. The block issues a one-cycle send request that carries the descriptor's stored byte count and a payload address: the stored pointer plus a fixed payload base, wrapped to 16 bits. It then stores the control word with the ready flag cleared and pulses a transmit-end cause. On the receive side the block keeps a ring head. A frame arrival is taken into the head slot when that slot's empty flag is set. The block then clears the flag, records the byte count, advances the head with wrap and pulses a receive-end cause. When the flag is clear the frame is refused, and the head and the table keep their values.

Top module: `bd_ring_engine`

## Requirements
- R1: After reset every word of both tables reads 0, rx_head is 0, and send_valid, irq_tx_end, frm_accept, frm_drop and irq_rx_end are all 0.
- R2: A byte address inside a table selects descriptor (address - table base) / 8. Address bits [2:1] pick the word: 0 control, 1 spare, 2 byte count, 3 pointer. Address bit 0 is ignored. Reads outside both tables return 0, and writes there change no word.
- R3: A host write to the spare, byte-count or pointer word of either table, or to a control word without bit 15 set, is stored unchanged and read back on host_rdata in the same cycle.
- R4: A host write to a transmit control word with bit 15 (ready) set makes send_valid high for exactly the next cycle. In that cycle send_len is the stored byte count, send_addr is (PAYLOAD_BASE + stored pointer) mod 65536, and irq_tx_end is high.
- R5: The transmit control word stored by such a write is the written value with bit 15 cleared.
- R6: When frm_valid is high and the receive control word at rx_head has bit 15 (empty) set, the next cycle shows frm_accept and irq_rx_end high. That control word then holds its old value with bit 15 cleared, and that slot's byte-count word holds frm_len.
- R7: Each accepted frame advances rx_head by one, from NDESC-1 back to 0.
- R8: When frm_valid is high and bit 15 of the receive control word at rx_head is clear, the next cycle shows frm_drop high and irq_rx_end low, and rx_head and that descriptor are unchanged.
- R9: A host write that sets bit 15 of a receive control word starts no send, and the word keeps bit 15.
- R10: Every cycle with frm_valid high is answered in the next cycle by exactly one of frm_accept or frm_drop. Neither is high after a cycle without frm_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, one 16-bit word |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Word at host_addr (combinational) |
| send_valid | output | 1 | One-cycle send request |
| send_addr | output | 16 | Payload start address of the send |
| send_len | output | 16 | Byte count of the send |
| irq_tx_end | output | 1 | Transmit-end cause pulse |
| frm_valid | input | 1 | Received frame arrives this cycle |
| frm_len | input | 16 | Byte count of the arriving frame |
| frm_accept | output | 1 | Frame taken into the ring (next cycle) |
| frm_drop | output | 1 | Frame refused (next cycle) |
| irq_rx_end | output | 1 | Receive-end cause pulse |
| rx_head | output | IDX_W | Current receive ring slot |

## Verification
The bound checker checks several things on every cycle. Each qualifying transmit control write is followed by a send request and a transmit-end cause, and no request appears without one. Each arriving frame gets exactly one answer, the head moves by exactly one wrapped step on acceptance, and it holds still on a drop. Only the bench's scenarios can show the data: the payload address arithmetic and its 16-bit wrap, the stored and cleared control words, the byte counts recorded on receive, and the address decode with its alias and out-of-window cases. The bench sweeps every word of both tables in a four-descriptor configuration and walks the receive ring through a full wrap.

// File: rtl/bd_pkg.sv
package bd_pkg;

  localparam int FLAG_BIT = 15;  // ready (transmit) / empty (receive)

  typedef enum logic [1:0] {
    FLD_CTRL  = 2'd0,
    FLD_SPARE = 2'd1,
    FLD_LEN   = 2'd2,
    FLD_PTR   = 2'd3
  } fld_e;

  function automatic logic [15:0] payload_addr(input logic [15:0] base,
                                                input logic [15:0] ptr);
    return base + ptr;
  endfunction

  function automatic int unsigned ring_next(input int unsigned idx,
                                            input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  function automatic logic [15:0] drop_flag(input logic [15:0] w);
    logic [15:0] r;
    r = w;
    r[FLAG_BIT] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/bd_addr_decode.sv
module bd_addr_decode #(
  parameter int unsigned NDESC = 64,
  parameter logic [15:0] BASE  = 16'h3000,
  localparam int IDX_W = $clog2(NDESC)
) (
  input  logic [15:0]       addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output bd_pkg::fld_e      fld
);
  localparam logic [16:0] SPAN = 17'(NDESC * 8);

  logic [16:0] off;
  logic        unused_off;

  assign off = {1'b0, addr} - {1'b0, BASE};
  assign hit = !off[16] && (off < SPAN);
  assign idx = off[IDX_W+2:3];
  assign fld = bd_pkg::fld_e'(off[2:1]);
  assign unused_off = ^{off[16:IDX_W+3], off[0]};
endmodule

// File: rtl/bd_desc_table.sv
module bd_desc_table #(
  parameter int unsigned NDESC = 64,
  localparam int IDX_W = $clog2(NDESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hwr_en,
  input  logic [IDX_W-1:0]  hwr_idx,
  input  bd_pkg::fld_e      hwr_fld,
  input  logic [15:0]       hwr_data,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [15:0]       upd_ctrl,
  input  logic [15:0]       upd_len,
  input  logic [IDX_W-1:0]  ra_idx,
  input  bd_pkg::fld_e      ra_fld,
  output logic [15:0]       ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [15:0]       rb_ctrl,
  output logic [15:0]       rb_len,
  output logic [15:0]       rb_ptr
);
  import bd_pkg::*;

  logic [15:0] mem [NDESC][4];

  // Internal update is written last so it wins a same-cycle collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < int'(NDESC); d++)
        for (int f = 0; f < 4; f++)
          mem[d][f] <= '0;
    end else begin
      if (hwr_en)
        mem[hwr_idx][hwr_fld] <= hwr_data;
      if (upd_en) begin
        mem[upd_idx][FLD_CTRL] <= upd_ctrl;
        mem[upd_idx][FLD_LEN]  <= upd_len;
      end
    end
  end

  assign ra_data = mem[ra_idx][ra_fld];
  assign rb_ctrl = mem[rb_idx][FLD_CTRL];
  assign rb_len  = mem[rb_idx][FLD_LEN];
  assign rb_ptr  = mem[rb_idx][FLD_PTR];
endmodule

// File: rtl/bd_tx_ctrl.sv
module bd_tx_ctrl #(
  parameter logic [15:0] PAYLOAD_BASE = 16'h1000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_wr,
  input  logic [15:0]  wdata,
  input  logic [15:0]  cur_ptr,
  input  logic [15:0]  cur_len,
  output logic         kick,
  output logic [15:0]  store_word,
  output logic         send_valid,
  output logic [15:0]  send_addr,
  output logic [15:0]  send_len,
  output logic         irq_tx_end
);
  import bd_pkg::*;

  assign kick       = ctrl_wr && wdata[FLAG_BIT];
  assign store_word = kick ? drop_flag(wdata) : wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_valid <= 1'b0;
      send_addr  <= '0;
      send_len   <= '0;
      irq_tx_end <= 1'b0;
    end else begin
      send_valid <= kick;
      irq_tx_end <= kick;
      if (kick) begin
        send_addr <= payload_addr(PAYLOAD_BASE, cur_ptr);
        send_len  <= cur_len;
      end
    end
  end
endmodule

// File: rtl/bd_rx_ctrl.sv
module bd_rx_ctrl #(
  parameter int unsigned NDESC = 64,
  localparam int IDX_W = $clog2(NDESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic [15:0]       frm_len,
  input  logic [15:0]       slot_ctrl,
  output logic [IDX_W-1:0]  head,
  output logic              take,
  output logic              reject,
  output logic [15:0]       upd_ctrl,
  output logic [15:0]       upd_len,
  output logic              frm_accept,
  output logic              frm_drop,
  output logic              irq_rx_end
);
  import bd_pkg::*;

  assign take     = frm_valid &&  slot_ctrl[FLAG_BIT];
  assign reject   = frm_valid && !slot_ctrl[FLAG_BIT];
  assign upd_ctrl = drop_flag(slot_ctrl);
  assign upd_len  = frm_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head       <= '0;
      frm_accept <= 1'b0;
      frm_drop   <= 1'b0;
      irq_rx_end <= 1'b0;
    end else begin
      if (take)
        head <= IDX_W'(ring_next(int'(head), NDESC));
      frm_accept <= take;
      frm_drop   <= reject;
      irq_rx_end <= take;
    end
  end
endmodule

// File: rtl/bd_ring_engine.sv
module bd_ring_engine #(
  parameter int unsigned NDESC        = 64,
  parameter logic [15:0] TX_BASE      = 16'h3000,
  parameter logic [15:0] RX_BASE      = 16'h3200,
  parameter logic [15:0] PAYLOAD_BASE = 16'h1000,
  localparam int IDX_W = $clog2(NDESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [15:0]       host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              send_valid,
  output logic [15:0]       send_addr,
  output logic [15:0]       send_len,
  output logic              irq_tx_end,
  input  logic              frm_valid,
  input  logic [15:0]       frm_len,
  output logic              frm_accept,
  output logic              frm_drop,
  output logic              irq_rx_end,
  output logic [IDX_W-1:0]  rx_head
);
  import bd_pkg::*;

  logic             tx_hit, rx_hit;
  logic [IDX_W-1:0] tx_idx, rx_idx;
  fld_e             tx_fld, rx_fld;

  bd_addr_decode #(.NDESC(NDESC), .BASE(TX_BASE)) u_tx_dec (
    .addr(host_addr), .hit(tx_hit), .idx(tx_idx), .fld(tx_fld));
  bd_addr_decode #(.NDESC(NDESC), .BASE(RX_BASE)) u_rx_dec (
    .addr(host_addr), .hit(rx_hit), .idx(rx_idx), .fld(rx_fld));

  // Named events for the checker.
  logic        tx_kick, rx_take, rx_reject;
  logic        tx_wr, rx_wr;
  logic [15:0] tx_store, tx_rdata, rx_rdata;
  logic [15:0] tx_ptr, tx_len, tx_ctrl_unused;
  logic [15:0] rx_slot_ctrl, rx_slot_len_unused, rx_slot_ptr_unused;
  logic [15:0] rx_upd_ctrl, rx_upd_len;

  assign tx_wr = host_we && tx_hit;
  assign rx_wr = host_we && rx_hit && !tx_hit;

  bd_tx_ctrl #(.PAYLOAD_BASE(PAYLOAD_BASE)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(tx_wr && (tx_fld == FLD_CTRL)), .wdata(host_wdata),
    .cur_ptr(tx_ptr), .cur_len(tx_len),
    .kick(tx_kick), .store_word(tx_store),
    .send_valid(send_valid), .send_addr(send_addr), .send_len(send_len),
    .irq_tx_end(irq_tx_end));

  bd_desc_table #(.NDESC(NDESC)) u_tx_tbl (
    .clk(clk), .rst_n(rst_n),
    .hwr_en(tx_wr), .hwr_idx(tx_idx), .hwr_fld(tx_fld), .hwr_data(tx_store),
    .upd_en(1'b0), .upd_idx('0), .upd_ctrl('0), .upd_len('0),
    .ra_idx(tx_idx), .ra_fld(tx_fld), .ra_data(tx_rdata),
    .rb_idx(tx_idx), .rb_ctrl(tx_ctrl_unused), .rb_len(tx_len), .rb_ptr(tx_ptr));

  bd_rx_ctrl #(.NDESC(NDESC)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .frm_valid(frm_valid), .frm_len(frm_len), .slot_ctrl(rx_slot_ctrl),
    .head(rx_head), .take(rx_take), .reject(rx_reject),
    .upd_ctrl(rx_upd_ctrl), .upd_len(rx_upd_len),
    .frm_accept(frm_accept), .frm_drop(frm_drop), .irq_rx_end(irq_rx_end));

  bd_desc_table #(.NDESC(NDESC)) u_rx_tbl (
    .clk(clk), .rst_n(rst_n),
    .hwr_en(rx_wr), .hwr_idx(rx_idx), .hwr_fld(rx_fld), .hwr_data(host_wdata),
    .upd_en(rx_take), .upd_idx(rx_head), .upd_ctrl(rx_upd_ctrl), .upd_len(rx_upd_len),
    .ra_idx(rx_idx), .ra_fld(rx_fld), .ra_data(rx_rdata),
    .rb_idx(rx_head), .rb_ctrl(rx_slot_ctrl), .rb_len(rx_slot_len_unused),
    .rb_ptr(rx_slot_ptr_unused));

  always_comb begin
    if (tx_hit)      host_rdata = tx_rdata;
    else if (rx_hit) host_rdata = rx_rdata;
    else             host_rdata = '0;
  end
endmodule

// File: rtl/bd_ring_engine_chk.sv
module bd_ring_engine_chk #(
  parameter int unsigned NDESC = 64,
  localparam int IDX_W = $clog2(NDESC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_kick,
  input logic             send_valid,
  input logic             irq_tx_end,
  input logic             frm_valid,
  input logic             frm_accept,
  input logic             frm_drop,
  input logic             irq_rx_end,
  input logic [IDX_W-1:0] rx_head
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NDESC - 1);

  assert_kick_sends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_kick |=> (send_valid && irq_tx_end));

  assert_send_needs_kick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    send_valid |-> $past(tx_kick));

  assert_one_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frm_accept, frm_drop}));

  assert_frame_answered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> (frm_accept || frm_drop));

  assert_no_spurious_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> (!frm_accept && !frm_drop));

  assert_head_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm_accept |-> (rx_head == (($past(rx_head) == LAST) ? '0 : $past(rx_head) + 1'b1)));

  assert_drop_holds_head_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_drop |-> $stable(rx_head));

  assert_drop_no_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_drop |-> !irq_rx_end);

  always @(posedge clk)
    if (rst_n) assert_head_range_R7: assert (int'(rx_head) < int'(NDESC));
endmodule

bind bd_ring_engine bd_ring_engine_chk #(.NDESC(NDESC)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_kick(tx_kick),
  .send_valid(send_valid), .irq_tx_end(irq_tx_end),
  .frm_valid(frm_valid), .frm_accept(frm_accept), .frm_drop(frm_drop),
  .irq_rx_end(irq_rx_end), .rx_head(rx_head));

// File: tb/bd_ring_engine_tb.sv
module bd_ring_engine_tb;
  localparam int          N   = 4;
  localparam int          IW  = 2;
  localparam logic [15:0] TXB = 16'h0100;
  localparam logic [15:0] RXB = 16'h0140;
  localparam logic [15:0] PB  = 16'hF000;

  logic clk = 0, rst_n = 0;
  logic host_we = 0;
  logic [15:0] host_addr = 0, host_wdata = 0, host_rdata;
  logic send_valid, irq_tx_end, frm_accept, frm_drop, irq_rx_end;
  logic [15:0] send_addr, send_len;
  logic frm_valid = 0;
  logic [15:0] frm_len = 0;
  logic [IW-1:0] rx_head;

  int vectors = 0, fails = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  bd_ring_engine #(.NDESC(N), .TX_BASE(TXB), .RX_BASE(RXB), .PAYLOAD_BASE(PB)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .send_valid(send_valid), .send_addr(send_addr), .send_len(send_len),
    .irq_tx_end(irq_tx_end), .frm_valid(frm_valid), .frm_len(frm_len),
    .frm_accept(frm_accept), .frm_drop(frm_drop), .irq_rx_end(irq_rx_end),
    .rx_head(rx_head));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] waddr(input logic [15:0] base, input int d, input int f);
    return base + 16'(d * 8 + f * 2);
  endfunction

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    @(negedge clk);
    host_addr = a;
    #1 v = host_rdata;
  endtask

  // Write; returns send outputs sampled in the cycle after the write edge.
  task automatic wr(input logic [15:0] a, input logic [15:0] d,
                    output logic sv, output logic [15:0] sa, output logic [15:0] sl,
                    output logic si);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    sv = send_valid; sa = send_addr; sl = send_len; si = irq_tx_end;
    host_we = 0;
  endtask

  task automatic frame(input logic [15:0] len, input logic exp_acc,
                       input int exp_head, input string tag);
    @(negedge clk);
    frm_valid = 1; frm_len = len;
    @(negedge clk);
    chk({tag, " accept"}, 32'(frm_accept), 32'(exp_acc));
    chk({tag, " drop"},   32'(frm_drop),   32'(!exp_acc));
    chk({tag, " irq_rx_end"}, 32'(irq_rx_end), 32'(exp_acc));
    chk({tag, " rx_head"}, 32'(rx_head), 32'(exp_head));
    frm_valid = 0;
    @(negedge clk);
    chk("R10 idle no answer", 32'({frm_accept, frm_drop}), 32'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, sa, sl;
    logic sv, si;
    int head;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 send_valid", 32'(send_valid), 0);
    chk("R1 irq", 32'({irq_tx_end, irq_rx_end}), 0);
    chk("R1 rx answers", 32'({frm_accept, frm_drop}), 0);
    chk("R1 rx_head", 32'(rx_head), 0);
    for (int t = 0; t < 2; t++)
      for (int d = 0; d < N; d++)
        for (int f = 0; f < 4; f++) begin
          rd(waddr(t == 0 ? TXB : RXB, d, f), v);
          chk("R1 word zero", 32'(v), 0);
        end

    // R2/R3 write and read back every word of both tables
    for (int t = 0; t < 2; t++)
      for (int d = 0; d < N; d++)
        for (int f = 0; f < 4; f++) begin
          v = 16'(16'h0A00 + t * 16'h2000 + d * 16 + f * 3);
          wr(waddr(t == 0 ? TXB : RXB, d, f), v, sv, sa, sl, si);
          chk("R3 no send on plain write", 32'(sv), 0);
        end
    for (int t = 0; t < 2; t++)
      for (int d = 0; d < N; d++)
        for (int f = 0; f < 4; f++) begin
          logic [15:0] r;
          rd(waddr(t == 0 ? TXB : RXB, d, f), r);
          chk("R3 readback", 32'(r), 32'(16'h0A00 + t * 16'h2000 + d * 16 + f * 3));
          rd(waddr(t == 0 ? TXB : RXB, d, f) | 16'h1, r);
          chk("R2 bit0 alias", 32'(r), 32'(16'h0A00 + t * 16'h2000 + d * 16 + f * 3));
        end
    // R2 outside the windows
    wr(TXB - 16'd2, 16'hBEEF, sv, sa, sl, si);
    wr(TXB + 16'(N * 8), 16'hBEEF, sv, sa, sl, si);
    wr(RXB + 16'(N * 8), 16'hBEEF, sv, sa, sl, si);
    rd(TXB - 16'd2, v);           chk("R2 below tx reads 0", 32'(v), 0);
    rd(TXB + 16'(N * 8), v);      chk("R2 gap reads 0", 32'(v), 0);
    rd(RXB + 16'(N * 8), v);      chk("R2 above rx reads 0", 32'(v), 0);
    rd(waddr(TXB, N - 1, 3), v);  chk("R2 last tx word untouched", 32'(v), 32'(16'h0A00 + (N - 1) * 16 + 9));
    rd(waddr(RXB, 0, 0), v);      chk("R2 first rx word untouched", 32'(v), 32'(16'h2A00));

    // R9 set bit 15 in receive control words: no send, flag kept
    for (int d = 0; d < N; d++) begin
      wr(waddr(RXB, d, 0), 16'(16'h8000 | d * 5), sv, sa, sl, si);
      chk("R9 no send", 32'({sv, si}), 0);
      rd(waddr(RXB, d, 0), v);
      chk("R9 flag kept", 32'(v), 32'(16'h8000 | d * 5));
    end

    // R4/R5 transmit on every descriptor, pointer sum wraps past 0xFFFF
    for (int d = 0; d < N; d++) begin
      logic [15:0] p, l;
      p = 16'(16'h0800 + d * 16'h0500);
      l = 16'(60 + d * 7);
      wr(waddr(TXB, d, 3), p, sv, sa, sl, si);
      wr(waddr(TXB, d, 2), l, sv, sa, sl, si);
      wr(waddr(TXB, d, 0), 16'(16'h8000 | d * 16'h11), sv, sa, sl, si);
      chk("R4 send_valid", 32'(sv), 1);
      chk("R4 send_addr", 32'(sa), 32'(16'(32'(PB) + 32'(p))));
      chk("R4 send_len", 32'(sl), 32'(l));
      chk("R4 irq_tx_end", 32'(si), 1);
      @(negedge clk);
      chk("R4 single pulse", 32'({send_valid, irq_tx_end}), 0);
      rd(waddr(TXB, d, 0), v);
      chk("R5 ready cleared", 32'(v), 32'(d * 16'h11));
    end

    // R6/R7 receive around the whole ring
    head = 0;
    for (int k = 0; k < N; k++) begin
      head = (head + 1) % N;
      frame(16'(64 + k * 100), 1'b1, head, "R7 accept");
      rd(waddr(RXB, k, 0), v);
      chk("R6 empty cleared", 32'(v), 32'(k * 5));
      rd(waddr(RXB, k, 2), v);
      chk("R6 length stored", 32'(v), 32'(64 + k * 100));
    end
    chk("R7 wrapped to 0", 32'(rx_head), 0);

    // R8 slot 0 not empty: drop, nothing changes
    frame(16'd999, 1'b0, 0, "R8 drop");
    rd(waddr(RXB, 0, 0), v); chk("R8 ctrl unchanged", 32'(v), 0);
    rd(waddr(RXB, 0, 2), v); chk("R8 len unchanged", 32'(v), 64);

    // Rearm slot 0 only: accept there, then drop on slot 1
    wr(waddr(RXB, 0, 0), 16'h8003, sv, sa, sl, si);
    frame(16'd1500, 1'b1, 1, "R6 rearmed accept");
    rd(waddr(RXB, 0, 0), v); chk("R6 ctrl bits kept", 32'(v), 3);
    rd(waddr(RXB, 0, 2), v); chk("R6 len", 32'(v), 1500);
    frame(16'd77, 1'b0, 1, "R8 drop slot1");
    rd(waddr(RXB, 1, 2), v); chk("R8 slot1 len unchanged", 32'(v), 164);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule